// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a one-bit serial stream and raises a flag whenever the five most recent bits match either of two fixed patterns: `10111` or `11001`. The stream is sampled on every rising clock edge. There is no framing and no valid qualifier, so each edge shifts in one new bit. Both patterns are tracked in a single state graph. Occurrences that overlap, and patterns that share a leading `1`/`11`, are still recognised.

The output is Moore-style. The flag is decoded from the state register alone. It becomes visible just after the clock edge that samples the fifth bit of a match, and it stays high for that one full clock period. An active-high synchronous reset drops all stored history.

Top module: `dual_seq_detector`

## Requirements
- R1: After a clock edge at which the five bits sampled on the last five edges (oldest first) read `10111`, `z` is 1 for the following clock period.
- R2: After a clock edge at which the five bits sampled on the last five edges (oldest first) read `11001`, `z` is 1 for the following clock period.
- R3: `z` is never 1 in two consecutive clock periods; each detection lasts exactly one period.
- R4: `z` depends only on the state. A change of `x` between clock edges leaves `z` unchanged.
- R5: Overlapping occurrences are each detected. For example, `10111001` gives a detection after its fifth bit and again after its eighth bit.
- R6: When `rst` is 1 at a rising edge, the machine goes to an idle state with no history, and `z` is 0 for the next period.
- R7: `z` is 0 unless at least five edges have passed since reset and one of the two patterns fills the last five samples. Bits sampled before a reset never count.
- R8: The stream `1011001011100110100`, applied right after reset, produces exactly three detections. They occur after the 7th, 11th and 14th bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; `x` is sampled on each edge |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial data bit |
| z | output | 1 | Detection flag, decoded from the state register |

## Verification
Every result is due one edge after its cause. The bit sampled at edge k is reflected in `z` from just after edge k until edge k+1. A reset at edge k forces `z` low for that same period. The bench drives `x` on the falling edge and reads `z` 2 ns after the rising edge. There it compares `z` with a 5-bit shift-register model and a count of edges since reset. To test the Moore property, `x` is also toggled mid-period and `z` is sampled again before the next rising edge.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int          PAT_LEN = 5;
  localparam logic [PAT_LEN-1:0] PAT_A = 5'b10111;
  localparam logic [PAT_LEN-1:0] PAT_B = 5'b11001;
  localparam int          ST_W    = 4;

  // Each state names the longest tail of the stream that is a prefix
  // of either pattern; the two hit states hold a completed pattern.
  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 4'd0,
    ST_P1    = 4'd1,  // "1"
    ST_P10   = 4'd2,  // "10"
    ST_P101  = 4'd3,  // "101"
    ST_P1011 = 4'd4,  // "1011"
    ST_P11   = 4'd5,  // "11"
    ST_P110  = 4'd6,  // "110"
    ST_P1100 = 4'd7,  // "1100"
    ST_HIT_A = 4'd8,  // "10111"
    ST_HIT_B = 4'd9   // "11001"
  } det_state_t;

  function automatic det_state_t det_step(det_state_t s, logic b);
    det_state_t n;
    case (s)
      ST_IDLE:  n = b ? ST_P1    : ST_IDLE;
      ST_P1:    n = b ? ST_P11   : ST_P10;
      ST_P10:   n = b ? ST_P101  : ST_IDLE;
      ST_P101:  n = b ? ST_P1011 : ST_P10;
      ST_P1011: n = b ? ST_HIT_A : ST_P110;
      ST_P11:   n = b ? ST_P11   : ST_P110;
      ST_P110:  n = b ? ST_P101  : ST_P1100;
      ST_P1100: n = b ? ST_HIT_B : ST_IDLE;
      ST_HIT_A: n = b ? ST_P11   : ST_P110;
      ST_HIT_B: n = b ? ST_P11   : ST_P10;
      default:  n = ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic det_is_hit(det_state_t s);
    return (s == ST_HIT_A) || (s == ST_HIT_B);
  endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  det_state_t cur,
  input  logic       x,
  output det_state_t nxt
);
  always_comb nxt = det_step(cur, x);
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  det_state_t nxt,
  output det_state_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end
endmodule

// File: rtl/seqdet_out.sv
module seqdet_out
  import seqdet_pkg::*;
(
  input  det_state_t cur,
  output logic       hit_a,
  output logic       hit_b,
  output logic       flag
);
  always_comb begin
    hit_a = (cur == ST_HIT_A);
    hit_b = (cur == ST_HIT_B);
    flag  = det_is_hit(cur);
  end
endmodule

// File: rtl/dual_seq_detector.sv
module dual_seq_detector
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic z
);
  det_state_t state_q;
  det_state_t state_d;
  logic       hit_a;
  logic       hit_b;

  seqdet_next u_next (
    .cur (state_q),
    .x   (x),
    .nxt (state_d)
  );

  seqdet_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (state_d),
    .cur (state_q)
  );

  seqdet_out u_out (
    .cur   (state_q),
    .hit_a (hit_a),
    .hit_b (hit_b),
    .flag  (z)
  );
endmodule

// File: rtl/seqdet_chk.sv
module seqdet_chk
  import seqdet_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic x,
  input logic z,
  input logic hit_a,
  input logic hit_b
);
  logic [PAT_LEN-1:0] win;
  logic [2:0]         since_rst;

  always_ff @(posedge clk) begin
    win <= {win[PAT_LEN-2:0], x};
    if (rst)                     since_rst <= 3'd0;
    else if (since_rst != 3'd5)  since_rst <= since_rst + 3'd1;
  end

  // R1
  pat_a_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd5 && win == PAT_A) |-> (z && hit_a));

  // R2
  pat_b_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd5 && win == PAT_B) |-> (z && hit_b));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    z |=> !z);

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> !z);

  // R7
  no_false_hit_chk: assert property (@(posedge clk) disable iff (rst)
    z |-> (since_rst == 3'd5 && (win == PAT_A || win == PAT_B)));
endmodule

bind dual_seq_detector seqdet_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .x     (x),
  .z     (z),
  .hit_a (hit_a),
  .hit_b (hit_b)
);

// File: tb/test_dual_seq_detector.sv
`timescale 1ns/100ps
module test_dual_seq_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic z;

  int n_checks = 0;
  int n_fail   = 0;
  int n_hits   = 0;
  logic [4:0] hist = 5'd0;
  int         depth = 0;
  logic       prev_exp = 1'b0;

  always #2.5 clk = ~clk;

  dual_seq_detector i_dual_seq_detector (.clk(clk), .rst(rst), .x(x), .z(z));

  task automatic check(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: z=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; x = 1'b0;
    @(posedge clk); #2;
    check("R6", z, 1'b0);
    hist = 5'd0; depth = 0; prev_exp = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic put_bit(input logic b);
    logic exp;
    string tag;
    if (!(rst === 1'b0)) @(negedge clk);
    else @(negedge clk);
    x = b;
    @(posedge clk); #2;
    hist = {hist[3:0], b};
    if (depth < 5) depth++;
    exp = (depth >= 5) && (hist == 5'b10111 || hist == 5'b11001);
    if (exp && hist == 5'b10111) tag = "R1";
    else if (exp)                tag = "R2";
    else if (prev_exp)           tag = "R3";
    else                         tag = "R7";
    check(tag, z, exp);
    if (z === 1'b1) n_hits++;
    prev_exp = exp;
  endtask

  task automatic put_str(input string s);
    for (int i = 0; i < s.len(); i++) put_bit(s[i] == "1");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(posedge clk); #2;
    check("R6", z, 1'b0);
    @(negedge clk); rst = 1'b0;

    // R8: required stream, three detections after bits 7, 11, 14
    do_reset();
    n_hits = 0;
    for (int i = 0; i < 19; i++) begin
      string s = "1011001011100110100";
      put_bit(s[i] == "1");
      if (i == 6 || i == 10 || i == 13) check("R8", z, 1'b1);
    end
    n_checks++;
    if (n_hits != 3) begin
      n_fail++;
      $display("FAIL R8: hits=%0d expected 3", n_hits);
    end

    // R5: overlapping detections in 10111001
    do_reset();
    put_str("1011");
    put_bit(1'b1); check("R5", z, 1'b1);
    put_str("00");
    put_bit(1'b1); check("R5", z, 1'b1);

    // R4: toggling x mid-period leaves z alone
    do_reset();
    put_str("1011");
    @(negedge clk); x = 1'b1;
    @(posedge clk); #1;
    check("R4", z, 1'b1);
    x = 1'b0; #1;
    check("R4", z, 1'b1);
    @(negedge clk); #0.5;
    x = 1'b1; #1;
    check("R4", z, 1'b1);
    hist = 5'b10111; depth = 5; prev_exp = 1'b1;

    // R6/R7: history before reset does not count
    do_reset();
    put_str("1011");
    do_reset();
    put_bit(1'b1); check("R7", z, 1'b0);
    put_str("1100");
    put_bit(1'b1); check("R2", z, 1'b1);

    // Exhaustive sweep of every 10-bit sequence from reset (R1, R2, R3, R7)
    for (int v = 0; v < 1024; v++) begin
      do_reset();
      for (int k = 9; k >= 0; k--) put_bit(v[k]);
    end

    // Long continuous run from an LFSR without resets
    do_reset();
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        put_bit(lfsr[0]);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule